// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one timer channel of a memory-mapped timer unit. Software writes a start value into the load register and a control word into the control register. While enabled, the counter steps down by one on every cycle in which the chosen tick input is high. When the counter is at zero and a tick arrives, the counter underflows and raises a level interrupt. In periodic mode it then restarts from the load value. In free-run mode it wraps to all ones.

Two tick-enable inputs stand in for the slow (about 2 kHz) and fast (about 508 kHz, nominally 508469 Hz) count clocks. A control bit selects which one drives the count. The dividers that make these ticks are outside the block. Software clears the interrupt by writing any data word to the clear register. The counter width is a parameter, either 16 or 32 bits.

Top module: `dntimer_chan`

## Requirements
- R1: After reset, the load register, the counter, the control register and the interrupt output are all zero.
- R2: The register word offsets are load at 0x0, current value at 0x4, control at 0x8 and interrupt clear at 0xC, decoded from address bits [3:2]. The value register is read-only, and a write to it changes nothing. The clear register reads as zero.
- R3: Control bit 7 enables counting, bit 6 selects periodic mode when set, and bit 3 selects the fast tick when set and the slow tick when clear. Every other control bit reads back as zero.
- R4: A load write while the channel is disabled also copies the value into the counter on the same clock edge. A load write while the channel is enabled changes only the load register.
- R5: While enabled, the counter drops by one on each clock edge at which the selected tick is high. The unselected tick has no effect. While disabled, the counter holds its value.
- R6: In periodic mode, a selected tick with the counter at zero reloads the counter from the load register and sets the interrupt.
- R7: In free-run mode, a selected tick with the counter at zero wraps the counter to all ones and sets the interrupt.
- R8: The interrupt is a level that stays high until software writes to the clear register. Any data value written there clears it.
- R9: When an underflow and a clear write land on the same clock edge, the interrupt stays set.
- R10: The counter width is 16 or 32 bits. The load and value registers read back zero-extended to 32 bits, and the upper data bits of a load write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_slow_i | input | 1 | Slow count tick enable (about 2 kHz) |
| tick_fast_i | input | 1 | Fast count tick enable (about 508 kHz) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Underflow interrupt, level |

## Verification
Two events can fall on the same clock edge: an underflow, which sets the interrupt, and a software write to the clear register, which drops it. The bench provokes this on purpose. It parks the counter at zero in free-run mode, then raises the selected tick in the very cycle that carries the clear write, and requires the interrupt to still be high on the next cycle. The random phase also mixes clear writes with frequent underflows from small load values, and a cycle-accurate bench model judges every cycle on both the interrupt and the counter value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int REG_DW = 32;
   localparam int REG_AW = 4;
   // word index taken from address bits [3:2]
   localparam logic [1:0] WIDX_LOAD  = 2'd0;
   localparam logic [1:0] WIDX_VALUE = 2'd1;
   localparam logic [1:0] WIDX_CTRL  = 2'd2;
   localparam logic [1:0] WIDX_CLEAR = 2'd3;
   localparam int BIT_EN   = 7;
   localparam int BIT_PER  = 6;
   localparam int BIT_FAST = 3;

   typedef struct packed {
      logic en;
      logic periodic;
      logic fast;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [REG_DW-1:0] wdata_i,
   output tmr_ctrl_t         ctrl_o,
   output logic [CNT_W-1:0]  load_q_o,
   output logic [CNT_W-1:0]  load_data_o,
   output logic              load_wr_o,
   output logic              clr_wr_o
);
   logic [1:0] widx;
   logic       ctrl_wr;
   logic       unused_bits;

   assign widx        = addr_i[3:2];
   assign load_wr_o   = we_i && (widx == WIDX_LOAD);
   assign ctrl_wr     = we_i && (widx == WIDX_CTRL);
   assign clr_wr_o    = we_i && (widx == WIDX_CLEAR);
   assign load_data_o = wdata_i[CNT_W-1:0];
   assign unused_bits = ^{addr_i[1:0], wdata_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o   <= '0;
         load_q_o <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl_o.en       <= wdata_i[BIT_EN];
            ctrl_o.periodic <= wdata_i[BIT_PER];
            ctrl_o.fast     <= wdata_i[BIT_FAST];
         end
         if (load_wr_o) load_q_o <= wdata_i[CNT_W-1:0];
      end
   end

   AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ctrl_o.en == $past(wdata_i[BIT_EN]))); // R3
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_ctrl_t        ctrl_i,
   input  logic [CNT_W-1:0] load_q_i,
   input  logic [CNT_W-1:0] load_data_i,
   input  logic             load_wr_i,
   input  logic             tick_slow_i,
   input  logic             tick_fast_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             underflow_o
);
   logic tick_sel;
   logic step;

   assign tick_sel    = ctrl_i.fast ? tick_fast_i : tick_slow_i;
   assign step        = ctrl_i.en && tick_sel;
   assign underflow_o = step && (cnt_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (step) begin
         if (cnt_o == '0) cnt_o <= ctrl_i.periodic ? load_q_i : '1;
         else             cnt_o <= cnt_o - 1'b1;
      end else if (load_wr_i && !ctrl_i.en) begin
         cnt_o <= load_data_i;
      end
   end

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_i.en && !load_wr_i) |=> $stable(cnt_o)); // R5
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_o != '0) |=> (cnt_o == CNT_W'($past(cnt_o) - 1'b1))); // R5
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_o && ctrl_i.periodic) |=> (cnt_o == $past(load_q_i))); // R6
   AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_o && !ctrl_i.periodic) |=> (&cnt_o)); // R7
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (load_wr_i && !ctrl_i.en) |=> (cnt_o == $past(load_data_i))); // R4
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     irq_o <= 1'b0;
      else if (set_i) irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
   end

   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> irq_o); // R6
   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !irq_o); // R8
   AST_IRQ_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> irq_o); // R9
   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(irq_o)); // R8
endmodule

// File: rtl/dntimer_chan.sv
module dntimer_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_slow_i,
   input  logic              tick_fast_i,
   input  logic              reg_we_i,
   input  logic [3:0]        reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic              irq_o
);
   localparam int PAD_W = REG_DW - CNT_W;

   generate
      if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
         $error("dntimer_chan: CNT_W must be 16 or 32");
      end
   endgenerate

   tmr_ctrl_t        ctrl;
   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] load_data;
   logic             load_wr;
   logic             clr_wr;
   logic [CNT_W-1:0] cnt;
   logic             underflow;
   logic [31:0]      load_ext;
   logic [31:0]      cnt_ext;
   logic [31:0]      ctrl_ext;

   tmr_regs #(.CNT_W(CNT_W)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (reg_we_i),
      .addr_i      (reg_addr_i),
      .wdata_i     (reg_wdata_i),
      .ctrl_o      (ctrl),
      .load_q_o    (load_q),
      .load_data_o (load_data),
      .load_wr_o   (load_wr),
      .clr_wr_o    (clr_wr)
   );

   tmr_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_i      (ctrl),
      .load_q_i    (load_q),
      .load_data_i (load_data),
      .load_wr_i   (load_wr),
      .tick_slow_i (tick_slow_i),
      .tick_fast_i (tick_fast_i),
      .cnt_o       (cnt),
      .underflow_o (underflow)
   );

   tmr_irq irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (underflow),
      .clr_i (clr_wr),
      .irq_o (irq_o)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign load_ext = {{PAD_W{1'b0}}, load_q};
         assign cnt_ext  = {{PAD_W{1'b0}}, cnt};
      end else begin : g_full
         assign load_ext = load_q;
         assign cnt_ext  = cnt;
      end
   endgenerate

   always_comb begin
      ctrl_ext           = '0;
      ctrl_ext[BIT_EN]   = ctrl.en;
      ctrl_ext[BIT_PER]  = ctrl.periodic;
      ctrl_ext[BIT_FAST] = ctrl.fast;
   end

   always_comb begin
      case (reg_addr_i[3:2])
         WIDX_LOAD:  reg_rdata_o = load_ext;
         WIDX_VALUE: reg_rdata_o = cnt_ext;
         WIDX_CTRL:  reg_rdata_o = ctrl_ext;
         default:    reg_rdata_o = '0;
      endcase
   end

   AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i[3:2] == WIDX_CTRL) |-> ((reg_rdata_o & ~32'h0000_00C8) == 32'h0)); // R3
   AST_VALUE_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && reg_addr_i[3:2] == WIDX_VALUE && !ctrl.en) |=> $stable(cnt)); // R2
endmodule

// File: tb/dntimer_chan_tb.sv
module dntimer_chan_tb_top;
   localparam int W = 16;
   localparam logic [31:0] MASK = 32'h0000_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_slow = 1'b0;
   logic        tick_fast = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = 4'h4;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   logic [31:0] m_load, m_cnt, m_ctrl;
   logic        m_irq;

   always #2 clk = ~clk;

   dntimer_chan #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_slow_i(tick_slow), .tick_fast_i(tick_fast),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; addr = 4'h4;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
      addr = 4'h4;
   endtask

   task automatic pulse(input bit fast, input int n);
      @(negedge clk);
      if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
      repeat (n) @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_mask(input logic [31:0] d);
      return d & 32'h0000_00C8;
   endfunction

   // one clock of the reference model
   task automatic model_step(input bit w, input logic [3:0] a, input logic [31:0] d,
                             input bit ts, input bit tf);
      bit en, tk, uf;
      en = m_ctrl[7];
      tk = m_ctrl[3] ? tf : ts;
      uf = en && tk && (m_cnt == 0);
      if (en && tk)                        m_cnt = uf ? (m_ctrl[6] ? m_load : MASK) : m_cnt - 1;
      else if (w && a[3:2] == 2'd0 && !en) m_cnt = d & MASK;
      if (w && a[3:2] == 2'd0) m_load = d & MASK;
      if (w && a[3:2] == 2'd2) m_ctrl = ctrl_mask(d);
      if (uf)                            m_irq = 1'b1;
      else if (w && a[3:2] == 2'd3)      m_irq = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd(4'h0, v); chk("R1 load", v, 32'h0);
      rd(4'h4, v); chk("R1 value", v, 32'h0);
      rd(4'h8, v); chk("R1 ctrl", v, 32'h0);

      // R4 R10 load while disabled, truncated
      wr(4'h0, 32'h0001_2345);
      rd(4'h4, v); chk("R4 copy to counter", v, 32'h2345);
      rd(4'h0, v); chk("R10 load truncated", v, 32'h2345);
      // R2 value register read-only, clear reads zero
      wr(4'h4, 32'h1111);
      rd(4'h4, v); chk("R2 value read-only", v, 32'h2345);
      rd(4'hC, v); chk("R2 clear reads zero", v, 32'h0);
      // R3 control bits
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, v); chk("R3 ctrl readback", v, 32'h0000_00C8);
      // R4 load while enabled
      wr(4'h0, 32'h5);
      rd(4'h4, v); chk("R4 enabled no copy", v, 32'h2345);
      rd(4'h0, v); chk("R4 load reg", v, 32'h5);
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h5);
      wr(4'h8, 32'hC8);
      // R5 unselected tick ignored, selected counts
      pulse(0, 3);
      rd(4'h4, v); chk("R5 slow ignored", v, 32'h5);
      pulse(1, 2);
      rd(4'h4, v); chk("R5 decrement", v, 32'h3);
      pulse(1, 3);
      rd(4'h4, v); chk("R5 reach zero", v, 32'h0);
      chk("R6 no irq at zero", {31'b0, irq}, 32'h0);
      // R6 periodic reload
      pulse(1, 1);
      rd(4'h4, v); chk("R6 reload", v, 32'h5);
      chk("R6 irq set", {31'b0, irq}, 32'h1);
      repeat (3) @(negedge clk);
      chk("R8 irq level held", {31'b0, irq}, 32'h1);
      wr(4'hC, 32'hDEAD_BEEF);
      chk("R8 clear any data", {31'b0, irq}, 32'h0);
      // R5 disabled hold
      wr(4'h8, 32'h0);
      pulse(1, 4);
      rd(4'h4, v); chk("R5 hold disabled", v, 32'h5);
      // R7 free-run wrap on slow tick
      wr(4'h0, 32'h1);
      wr(4'h8, 32'h80);
      pulse(1, 2);
      rd(4'h4, v); chk("R5 fast ignored", v, 32'h1);
      pulse(0, 1);
      rd(4'h4, v); chk("R7 to zero", v, 32'h0);
      pulse(0, 1);
      rd(4'h4, v); chk("R7 wrap all ones", v, 32'hFFFF);
      chk("R7 irq set", {31'b0, irq}, 32'h1);
      rd(4'h0, v); chk("R7 load kept", v, 32'h1);
      // R9 underflow and clear on the same edge
      wr(4'hC, 32'h0);
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h0);
      wr(4'h8, 32'h80);
      chk("R9 irq clear before", {31'b0, irq}, 32'h0);
      @(negedge clk);
      tick_slow = 1'b1; we = 1'b1; addr = 4'hC; wdata = 32'h0;
      @(negedge clk);
      tick_slow = 1'b0; we = 1'b0; addr = 4'h4;
      chk("R9 irq survives clear", {31'b0, irq}, 32'h1);
      rd(4'h4, v); chk("R9 counter wrapped", v, 32'hFFFF);
      wr(4'hC, 32'h7);
      chk("R8 clear after race", {31'b0, irq}, 32'h0);

      // random phase from a known state
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h40);
      wr(4'hC, 32'h0);
      m_load = 32'h40; m_cnt = 32'h40; m_ctrl = 32'h0; m_irq = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         bit w, ts, tf;
         logic [3:0] a;
         logic [31:0] d;
         @(negedge clk);
         we = 1'b0; addr = 4'h4;
         #1;
         chk("R5 random value", rdata, m_cnt);
         chk("R9 random irq", {31'b0, irq}, {31'b0, m_irq});
         w  = ($urandom_range(0, 5) == 0);
         a  = {2'($urandom_range(0, 3)), 2'b00};
         d  = ($urandom_range(0, 3) == 0) ? $urandom : ($urandom & 32'h1F);
         if (w && a == 4'h8) d = d | ($urandom_range(0, 1) ? 32'h80 : 32'h0) | 32'h40 * $urandom_range(0, 1)
                                   | 32'h08 * $urandom_range(0, 1);
         ts = ($urandom_range(0, 1) == 1);
         tf = ($urandom_range(0, 1) == 1);
         we = w; addr = w ? a : 4'h4; wdata = d;
         tick_slow = ts; tick_fast = tf;
         model_step(w, a, d, ts, tf);
      end
      @(negedge clk);
      we = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0; addr = 4'h4;
      #1;
      chk("R6 final value", rdata, m_cnt);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule